// File: doc/BRIEF.md
# Dual-Edge Coarse Count Synchronizer

This block turns the arrival of an asynchronous hit into a coarse timestamp taken from a free-running binary counter that advances on every rising edge of the reference clock. The hit is registered twice, once by a rising-edge flop and once by a falling-edge flop. A select input tells the block in which half of the clock period the hit arrived. A multiplexer uses it to pick one of the two samples. A third flop, clocked on the falling edge, turns the chosen sample into the synchronized hit. The counter is copied on that falling edge, while it is halfway between two increments and cannot be moving.

A single counter and a single capture register are enough, because the clock phase is resolved at the sampling stage. The raw capture is always one count above the counter value that was current when the hit arrived. The timestamp arithmetic subtracts two from the raw capture, and the block presents that corrected value directly, together with a one-cycle valid strobe. Only the first hit after reset is recorded. The controller re-arms the block by pulsing reset.

Top module: `coarse_sync`

## Requirements
- R1: The counter is CNT_W bits wide (default 12). Reset clears it to zero. It adds one on each rising clock edge while reset is released and wraps from all-ones to zero.
- R2: When hit_low_half_i is 0 (the hit rose while the clock was high), the falling-edge sample is used. The capture happens on the second falling edge after the hit rises, and coarse_valid_o is high after the second rising edge after the hit.
- R3: When hit_low_half_i is 1 (the hit rose while the clock was low), the rising-edge sample is used. The capture happens on the falling edge that follows the first rising edge after the hit, and coarse_valid_o is high after the second rising edge after the hit.
- R4: coarse_o equals (C + 1 - 2) modulo 2^CNT_W. C is the counter value at the moment the hit rose, and the +1 is the fixed skew of the raw capture.
- R5: coarse_valid_o is high for exactly one clock cycle per capture.
- R6: After the first capture, any further hit, in either half cycle, is ignored: coarse_valid_o stays low and coarse_o keeps its value until the next reset.
- R7: During reset (rst_n low, synchronous), coarse_o reads 0 and coarse_valid_o reads 0. After reset is released, the block is armed for a new hit.
- R8: Once captured, coarse_o stays constant on every following cycle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also re-arms the block |
| hit_i | input | 1 | Asynchronous hit, held high until the capture is done |
| hit_low_half_i | input | 1 | 1: hit rose while clk was low; 0: while clk was high |
| coarse_o | output | CNT_W | Corrected coarse count (raw capture minus 2, wrapped) |
| coarse_valid_o | output | 1 | One-cycle strobe marking a new coarse_o |

## Verification
The bench sweeps the delay between reset and hit across more than one full counter period, in both half cycles. This covers every count value, including the wrap of the counter and the wrap of the minus-two correction near zero. A design that picks the wrong sample for a half cycle would capture one count early or late, or raise the strobe a cycle off. A correction with the wrong offset, or one that saturates instead of wrapping, shows up at counts 0 and 1. After every capture, a second hit in the opposite half cycle is applied. A block that fails to disarm would raise a second strobe or overwrite the stored count.

// File: rtl/ccs_pkg.sv
// Shared constants and types for the dual-edge coarse count synchronizer.
// Assumes: nothing beyond IEEE 1800-2017.
package ccs_pkg;

    // Offset subtracted from the raw capture in the timestamp arithmetic
    localparam int unsigned CCS_LATCH_SKEW = 2;

    // Which edge's sample feeds the synchronized hit
    typedef enum logic {
        PATH_FALL = 1'b0,
        PATH_RISE = 1'b1
    } ccs_path_e;

endpackage

// File: rtl/ccs_free_counter.sv
// Free-running coarse counter, advanced on each rising clock edge.
// Assumes: rst_n is synchronous to clk; wrap-around is the intended behaviour.
module ccs_free_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);

    // Count up by one, clear on reset, wrap naturally at all-ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else begin
            count_o <= count_o + 1'b1;
        end
    end

    // R1: the all-ones value is followed by zero
    p_count_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '1) |=> (count_o == '0));

endmodule

// File: rtl/ccs_edge_sampler.sv
// Samples the asynchronous hit on both clock edges, picks one sample by the
// half-cycle indication, and re-times the pick on the falling edge.
// Assumes: hit_i and hit_low_half_i stay stable until the capture is done.
module ccs_edge_sampler
    import ccs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic hit_low_half_i,
    output logic sel_o,
    output logic syn_o
);

    logic      rise_smp_q;
    logic      fall_smp_q;
    ccs_path_e path;

    // First flop: hit as seen at the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_smp_q <= 1'b0;
        end else begin
            rise_smp_q <= hit_i;
        end
    end

    // Second flop: hit as seen at the falling edge
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_smp_q <= 1'b0;
        end else begin
            fall_smp_q <= hit_i;
        end
    end

    // Multiplexer: the half-cycle indication chooses the sample path
    always_comb begin
        path  = hit_low_half_i ? PATH_RISE : PATH_FALL;
        sel_o = (path == PATH_RISE) ? rise_smp_q : fall_smp_q;
    end

    // Third flop: synchronized hit, aligned to the falling edge
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            syn_o <= 1'b0;
        end else begin
            syn_o <= sel_o;
        end
    end

    // R2: a falling-edge sample on the high-half path reaches the synchronized hit
    p_fall_path_r2: assert property (@(negedge clk) disable iff (!rst_n)
        (!hit_low_half_i && fall_smp_q) |=> syn_o);

    // R3: a rising-edge sample on the low-half path reaches the synchronized hit
    p_rise_path_r3: assert property (@(negedge clk) disable iff (!rst_n)
        (hit_low_half_i && rise_smp_q) |=> syn_o);

endmodule

// File: rtl/ccs_capture.sv
// Copies the counter on the falling edge where the synchronized hit first
// appears, applies the fixed correction, and strobes valid on the next
// rising edge. One capture per reset.
// Assumes: count_i only changes on rising edges.
module ccs_capture
    import ccs_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             sel_i,
    input  logic             syn_i,
    output logic [CNT_W-1:0] coarse_o,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] SKEW = CNT_W'(CCS_LATCH_SKEW);

    logic armed_q;
    logic cap_evt_q;
    logic take;

    // Capture condition: armed and the synchronized hit is rising at this edge
    always_comb begin
        take = armed_q && sel_i && !syn_i;
    end

    // Falling-edge capture of the stable counter, with arm bookkeeping
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b1;
            cap_evt_q <= 1'b0;
            coarse_o  <= '0;
        end else begin
            cap_evt_q <= take;
            if (take) begin
                armed_q  <= 1'b0;
                coarse_o <= count_i - SKEW;
            end
        end
    end

    // Valid strobe, moved to the rising-edge domain for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= cap_evt_q;
        end
    end

    // R5: the strobe never lasts two cycles
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: a strobe is only seen once the block has disarmed
    p_valid_disarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !armed_q);

    // R6: no new capture while disarmed
    p_no_recapture_r6: assert property (@(negedge clk) disable iff (!rst_n)
        !armed_q |=> $stable(coarse_o));

    // R8: the stored count stays put after its strobe
    p_coarse_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !valid_o) |=> $stable(coarse_o));

endmodule

// File: rtl/coarse_sync.sv
// Top of the dual-edge coarse count synchronizer: one counter, one
// three-flop sampler with a path multiplexer, one capture register.
// Assumes: hit_i is held high until coarse_valid_o, and hit_low_half_i is
// valid from the hit's rise onward.
module coarse_sync #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             hit_low_half_i,
    output logic [CNT_W-1:0] coarse_o,
    output logic             coarse_valid_o
);

    logic [CNT_W-1:0] count;
    logic             sel_hit;
    logic             syn_hit;

    ccs_free_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count)
    );

    ccs_edge_sampler u_sampler (
        .clk            (clk),
        .rst_n          (rst_n),
        .hit_i          (hit_i),
        .hit_low_half_i (hit_low_half_i),
        .sel_o          (sel_hit),
        .syn_o          (syn_hit)
    );

    ccs_capture #(.CNT_W(CNT_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_i  (count),
        .sel_i    (sel_hit),
        .syn_i    (syn_hit),
        .coarse_o (coarse_o),
        .valid_o  (coarse_valid_o)
    );

endmodule

// File: tb/coarse_sync_tb.sv
`timescale 1ns/1ps
// Sweeps hit placement over every count of a small counter, in both halves.
module coarse_sync_tb;

    localparam int unsigned W    = 6;
    localparam int unsigned MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hit = 1'b0;
    logic         hit_low = 1'b0;
    logic [W-1:0] coarse;
    logic         valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int unsigned ref_cnt = 0;

    coarse_sync #(.CNT_W(W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hit_i          (hit),
        .hit_low_half_i (hit_low),
        .coarse_o       (coarse),
        .coarse_valid_o (valid)
    );

    always #4 clk = ~clk;

    // R1 model: counter value from the requirement
    always @(posedge clk) begin
        if (!rst_n) ref_cnt <= 0;
        else        ref_cnt <= (ref_cnt + 1) & MASK;
    end

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        hit = 1'b0; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R7 valid in reset", valid, 0);
        check("R7 coarse in reset", coarse, 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R7 valid after release", valid, 0);
    endtask

    task automatic place_hit(input bit low_half, output int unsigned c);
        if (low_half) begin
            @(negedge clk); #1;
        end else begin
            @(posedge clk); #1;
        end
        c       = ref_cnt;
        hit_low = low_half;
        hit     = 1'b1;
    endtask

    task automatic run_one(input bit low_half, input int wait_cycles);
        int unsigned c;
        int unsigned exp;
        string tag;
        tag = low_half ? "R3" : "R2";
        do_reset();
        repeat (wait_cycles) @(posedge clk);
        place_hit(low_half, c);
        exp = (c + 1 - 2) & MASK;  // R4 with R1 wrap
        @(posedge clk); #2;
        check({tag, " valid not early"}, valid, 0);
        @(posedge clk); #2;
        check({tag, " valid on second rising edge"}, valid, 1);
        check("R4 corrected count", coarse, exp);
        @(posedge clk); #2;
        check("R5 valid one cycle", valid, 0);
        check("R8 coarse held", coarse, exp);
        hit = 1'b0;
        repeat (2) @(posedge clk);
        place_hit(!low_half, c);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #2;
            check("R6 second hit no strobe", valid, 0);
        end
        check("R6 second hit no overwrite", coarse, exp);
        hit = 1'b0;
    endtask

    initial begin
        for (int ph = 0; ph < 2; ph++) begin
            for (int w = 0; w < 70; w++) begin
                run_one(ph[0], w);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule